// File: doc/BRIEF.md
# Pulse-Driven Volume Step Controller

This block turns two push-button style input pins into a volume step value. Each pin idles high. A press pulls it low, and when it is released the block counts one step: up for one pin, down for the other. The count is held as a 7-bit value that stops at both ends of its range. A third pin works the same way, but each qualified press flips a mute flag.

Every pin passes through a two-flop synchronizer. It then goes through a debounce counter, so a press counts only if it stayed low for at least `DEB_CYC` clock cycles. The count happens on release, never while the button is held.

A simple register port stands in for the get/set access of a volume knob node. The read word always shows the current state. A write loads volume and mute directly, and it wins over any pin event in the same cycle. A one-cycle strobe marks every cycle in which the volume or mute value has just changed.

Top module: `vol_step_ctrl`

## Requirements
- R1: After reset, `vol_o` is 0, `mute_o` is 0, `chg_o` is 0 and `rd_data_o` is 0.
- R2: A low period on `up_n_i` of at least `DEB_CYC` cycles followed by a return high raises `vol_o` by exactly 1, within 4 cycles of the release and not before it.
- R3: A qualified low pulse on `dn_n_i` lowers `vol_o` by exactly 1, with the same timing as R2.
- R4: A low period shorter than `DEB_CYC` cycles on any pin changes neither `vol_o` nor `mute_o`.
- R5: `vol_o` saturates: an up event at 127 leaves 127, and a down event at 0 leaves 0.
- R6: Up and down events that qualify in the same cycle cancel, and `vol_o` is unchanged.
- R7: Each qualified low pulse on `mute_n_i` inverts `mute_o`. This is independent of volume events in the same cycle.
- R8: When `reg_wr_i` is high at a clock edge, the block loads `vol_o` from `reg_wdata_i[6:0]` and `mute_o` from `reg_wdata_i[7]`, ignoring any pin event in that cycle.
- R9: `rd_data_o` bit 7 is the mute flag, bits 6:0 are the volume, and bits 31:8 read as zero.
- R10: `chg_o` is high for exactly the cycles in which `vol_o` or `mute_o` differs from its value one cycle earlier. A write of the current value gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n_i | input | 1 | Volume-up pin, active low, asynchronous |
| dn_n_i | input | 1 | Volume-down pin, active low, asynchronous |
| mute_n_i | input | 1 | Mute-toggle pin, active low, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data: bit 7 mute, bits 6:0 volume |
| rd_data_o | output | 32 | Read word: {24 zeros, mute, volume} |
| vol_o | output | 7 | Volume step value |
| mute_o | output | 1 | Mute flag |
| chg_o | output | 1 | One-cycle strobe when volume or mute changes |

## Verification
The hardest case to reach from the ports is a register write that lands in exactly the cycle in which a debounced release event is ready to be applied. That event exists for only one cycle, and it appears two synchronizer edges after the pin rises. The bench releases the up pin after a qualified press and counts the edges. It raises the write strobe so that it is sampled at the third edge after the release, which is the edge where the step would otherwise be applied. It then expects the written value rather than that value plus one. Random runs mix presses, short glitches, two-pin presses and writes near 0 and 127, so that saturation and cancellation keep coming back.

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl #(
  parameter int DEB_CYC = 4,
  parameter int VOL_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_n_i,
  input  logic             dn_n_i,
  input  logic             mute_n_i,
  input  logic             reg_wr_i,
  input  logic [VOL_W:0]   reg_wdata_i,
  output logic [31:0]      rd_data_o,
  output logic [VOL_W-1:0] vol_o,
  output logic             mute_o,
  output logic             chg_o
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEB_CYC);
  localparam logic [VOL_W-1:0] VOL_MAX = {VOL_W{1'b1}};

  logic [2:0] pin_n;
  logic [2:0] ev;
  logic [VOL_W-1:0] vol_q, vol_d;
  logic mute_q, mute_d;

  assign pin_n = {mute_n_i, dn_n_i, up_n_i};

  for (genvar g = 0; g < 3; g++) begin : g_pin
    logic s1, s2;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        cnt <= '0;
      end else begin
        s1 <= pin_n[g];
        s2 <= s1;
        if (s2)                   cnt <= '0;
        else if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
      end
    end
    assign ev[g] = s2 && (cnt == CNT_FULL);
  end

  always_comb begin
    vol_d  = vol_q;
    mute_d = mute_q;
    if (reg_wr_i) begin
      vol_d  = reg_wdata_i[VOL_W-1:0];
      mute_d = reg_wdata_i[VOL_W];
    end else begin
      if (ev[0] && !ev[1] && vol_q != VOL_MAX)   vol_d = vol_q + 1'b1;
      else if (ev[1] && !ev[0] && vol_q != '0)   vol_d = vol_q - 1'b1;
      if (ev[2]) mute_d = !mute_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q  <= '0;
      mute_q <= 1'b0;
      chg_o  <= 1'b0;
    end else begin
      vol_q  <= vol_d;
      mute_q <= mute_d;
      chg_o  <= (vol_d != vol_q) || (mute_d != mute_q);
    end
  end

  assign vol_o     = vol_q;
  assign mute_o    = mute_q;
  assign rd_data_o = {{(31 - VOL_W){1'b0}}, mute_q, vol_q};
endmodule

// File: rtl/vol_step_chk.sv
module vol_step_chk #(
  parameter int VOL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_i,
  input logic [VOL_W:0]   reg_wdata_i,
  input logic [31:0]      rd_data_o,
  input logic [VOL_W-1:0] vol_o,
  input logic             mute_o,
  input logic             chg_o
);
  localparam logic [VOL_W-1:0] VMAX = {VOL_W{1'b1}};

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> (vol_o == $past(vol_o)) || (vol_o == $past(vol_o) + 1'b1)
                  || (vol_o == $past(vol_o) - 1'b1));

  p_no_wrap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && vol_o == VMAX) |=> vol_o != '0);

  p_no_wrap_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && vol_o == '0) |=> vol_o != VMAX);

  p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> (vol_o == $past(reg_wdata_i[VOL_W-1:0])) && (mute_o == $past(reg_wdata_i[VOL_W])));

  p_read_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[31:VOL_W+1] == '0) && (rd_data_o[VOL_W] == mute_o) && (rd_data_o[VOL_W-1:0] == vol_o));

  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> chg_o == ((vol_o != $past(vol_o)) || (mute_o != $past(mute_o))));
endmodule

bind vol_step_ctrl vol_step_chk #(.VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .rd_data_o(rd_data_o), .vol_o(vol_o), .mute_o(mute_o), .chg_o(chg_o)
);

// File: tb/tb_vol_step_ctrl.sv
module tb_vol_step_ctrl;
  localparam int DEB = 4;

  logic clk = 0, rst_n = 0;
  logic up_n = 1, dn_n = 1, mu_n = 1, wr = 0;
  logic [7:0] wdata = '0;
  logic [31:0] rd;
  logic [6:0] vol;
  logic mute, chg;

  int total = 0, bad = 0, chg_cnt = 0;
  logic [6:0] mv = '0;
  logic mm = 0;
  bit done = 0;

  vol_step_ctrl #(.DEB_CYC(DEB), .VOL_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .up_n_i(up_n), .dn_n_i(dn_n), .mute_n_i(mu_n),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .rd_data_o(rd), .vol_o(vol),
    .mute_o(mute), .chg_o(chg)
  );

  always #10 clk = ~clk;
  always @(negedge clk) if (chg) chg_cnt++;

  function automatic logic [6:0] step(input logic [6:0] v, input logic u, input logic d);
    if (u && !d && v != 7'd127) return v + 7'd1;
    if (d && !u && v != 7'd0)   return v - 7'd1;
    return v;
  endfunction

  task automatic ck(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic verify(input string tag, input int exp_chg);
    ck({tag, " vol"}, vol, mv);
    ck({tag, " mute"}, mute, mm);
    ck("R9 read word", rd, {24'd0, mm, mv});
    ck({"R10 strobe count ", tag}, chg_cnt, exp_chg);
  endtask

  task automatic press(input string tag, input logic [2:0] m, input int len);
    logic [6:0] pv; logic pm;
    pv = mv; pm = mm;
    @(negedge clk);
    chg_cnt = 0;
    up_n = !m[0]; dn_n = !m[1]; mu_n = !m[2];
    repeat (len) @(negedge clk);
    ck({tag, " no step while held"}, vol, pv);
    up_n = 1; dn_n = 1; mu_n = 1;
    repeat (6) @(negedge clk);
    if (len >= DEB) begin
      mv = step(mv, m[0], m[1]);
      if (m[2]) mm = !mm;
    end
    verify(tag, ((mv != pv) || (mm != pm)) ? 1 : 0);
  endtask

  task automatic write(input string tag, input logic [7:0] d);
    logic [6:0] pv; logic pm;
    pv = mv; pm = mm;
    @(negedge clk);
    chg_cnt = 0;
    wr = 1; wdata = d;
    @(negedge clk);
    wr = 0;
    repeat (2) @(negedge clk);
    mv = d[6:0]; mm = d[7];
    verify(tag, ((mv != pv) || (mm != pm)) ? 1 : 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    ck("R1 reset vol", vol, 0);
    ck("R1 reset mute", mute, 0);
    ck("R1 reset chg", chg, 0);
    ck("R1 reset read", rd, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    press("R5 down at zero", 3'b010, DEB + 2);
    press("R2 up", 3'b001, DEB + 2);
    press("R2 up exact length", 3'b001, DEB);
    press("R3 down", 3'b010, DEB + 3);
    press("R4 short up glitch", 3'b001, DEB - 1);
    press("R4 short mute glitch", 3'b100, 1);
    press("R6 up and down cancel", 3'b011, DEB + 2);
    press("R7 mute toggle", 3'b100, DEB + 2);
    press("R7 mute with up", 3'b101, DEB + 2);
    write("R8 write top", 8'h7F);
    press("R5 up at top", 3'b001, DEB + 2);
    write("R10 write same value", 8'h7F);
    write("R8 write mixed", 8'hA5);

    // R8: write in the same cycle as a qualified up event
    begin
      logic [6:0] pv; logic pm;
      pv = mv; pm = mm;
      @(negedge clk);
      chg_cnt = 0;
      up_n = 0;
      repeat (DEB + 2) @(negedge clk);
      up_n = 1;
      @(negedge clk);
      @(negedge clk);
      wr = 1; wdata = 8'h10;
      @(negedge clk);
      wr = 0;
      repeat (5) @(negedge clk);
      mv = 7'h10; mm = 1'b0;
      verify("R8 write beats pin event", ((mv != pv) || (mm != pm)) ? 1 : 0);
    end

    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: press("R2 rand up", 3'b001, DEB + int'($urandom_range(0, 4)));
        2, 3: press("R3 rand down", 3'b010, DEB + int'($urandom_range(0, 4)));
        4:    press("R7 rand mute", {1'b1, 2'($urandom_range(0, 3))}, DEB + 1);
        5:    press("R4 rand glitch", 3'($urandom_range(1, 7)), int'($urandom_range(1, DEB - 1)));
        6:    press("R6 rand cancel", 3'b011, DEB + 1);
        7:    write("R5 rand near top", {1'($urandom), 7'd127 - 7'($urandom_range(0, 2))});
        8:    write("R5 rand near bottom", {1'($urandom), 7'($urandom_range(0, 2))});
        default: write("R8 rand write", 8'($urandom));
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule